// File: doc/BRIEF.md
# Host bridge configuration register file

This block is the configuration space of function 0 of a PCI host bridge. It is reached through a simple byte-wide port: a function number, an 8-bit offset, a write data byte and a write strobe, with a read data byte that always shows the byte selected by the current function number and offset. The bank holds constant identification bytes, writable command and cache-line bytes, a status byte whose error bits are cleared by writing ones, and eighteen chipset-specific bytes at offsets 0x50 through 0x61.

Each offset carries its own write rule: plain write, masked write-one-to-clear, write with hardwired low bits, or ignored. The current values of the cache control byte (0x50), the two shadow control bytes (0x54, 0x55) and the system-management byte (0x60) are driven out continuously to memory decode logic outside the block. A cache-enable output follows bit 7 of 0x50.

A write lands on the rising clock edge where the strobe is high. The read port is combinational from stored state, so a read in the next cycle returns the new value.

Top module: `hb_cfg_space`

## Requirements
- R1: A read whose function number is not 0 returns 0xFF, whatever the offset.
- R2: Offsets 0x04, 0x05, 0x0C, 0x0D and 0x51 to 0x61 take the full written byte when the strobe is high and the function number is 0; a read of that offset in the next cycle returns the written byte.
- R3: A write to any other offset except 0x07 and 0x50 changes no stored byte. This covers the constants 0x00–0x03, 0x08, 0x0A, 0x0B and all unimplemented offsets. A write whose function number is not 0 also changes nothing.
- R4: A write to 0x07 clears each stored bit where the written byte has a 1 and mask 0xF9 has a 1. Bits where the write is 0 or the mask is 0 keep their value, so the reset bit 1 survives a write of 0xFF.
- R5: A write to 0x50 stores bits 7 to 3 from the written byte, while bits 2 to 0 always read 100b. The byte therefore reads 0x04 after reset.
- R6: Output cache_en_o equals bit 7 of 0x50 and follows a write to 0x50 from the next cycle.
- R7: After reset, offsets 0x00–0x03 read 0x60, 0x10, 0x81, 0x88. Offset 0x07 reads 0x02, 0x08 reads 0x04, 0x0B reads 0x06, and 0x51 and 0x52 read 0x01. Offset 0x5A reads 0x04, 0x5C reads 0xC0, 0x5D reads 0x20, 0x5F reads 0xFF and 0x60 reads 0x80.
- R8: Outputs reg50_o, reg54_o, reg55_o and reg60_o always equal the bytes a function-0 read of 0x50, 0x54, 0x55 and 0x60 returns.
- R9: Every offset not named in R5 or R7 reads 0x00 after reset, as do the unimplemented offsets at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_off | input | 8 | Byte offset in configuration space |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data for the current function and offset |
| reg50_o | output | 8 | Current cache control byte |
| reg54_o | output | 8 | Current low shadow control byte |
| reg55_o | output | 8 | Current high shadow control byte |
| reg60_o | output | 8 | Current system-management control byte |
| cache_en_o | output | 1 | Cache enable, bit 7 of the cache control byte |

## Verification
The assertions check four things on every cycle. A non-zero function always reads 0xFF. The 0x50 low bits never leave 100b. The status byte never gains a set bit. Stored state stays unchanged unless a function-0 write to a writable offset occurs. Only the bench scenarios can show the exact reset value of each of the 256 offsets, the readback of each plain byte, and that 0x07 keeps its unmaskable bit against a write of all ones. They also show that writes to constants and to other functions leave the visible bytes untouched.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;
    localparam int DATA_W  = 8;
    localparam int OFF_W   = 8;
    localparam logic [OFF_W-1:0] CHIP_LO = 8'h50;
    localparam logic [OFF_W-1:0] CHIP_HI = 8'h61;
    localparam int CHIP_N  = int'(CHIP_HI) - int'(CHIP_LO) + 1;
    localparam int IDX_W   = $clog2(CHIP_N);

    localparam logic [DATA_W-1:0] STAT_CLR_MASK = 8'hF9;
    localparam logic [2:0]        CACHE_LOW_BITS = 3'b100;

    // constant identification bytes
    localparam logic [DATA_W-1:0] ID_B0 = 8'h60;
    localparam logic [DATA_W-1:0] ID_B1 = 8'h10;
    localparam logic [DATA_W-1:0] ID_B2 = 8'h81;
    localparam logic [DATA_W-1:0] ID_B3 = 8'h88;
    localparam logic [DATA_W-1:0] REV_B = 8'h04;
    localparam logic [DATA_W-1:0] CLS_B = 8'h06;
    localparam logic [DATA_W-1:0] STAT_RST = 8'h02;

    typedef enum logic [1:0] {
        RULE_RO,
        RULE_PLAIN,
        RULE_W1C,
        RULE_HWLOW
    } wrule_e;

    typedef struct packed {
        logic [DATA_W-1:0]             cmd_lo;   // 0x04
        logic [DATA_W-1:0]             cmd_hi;   // 0x05
        logic [DATA_W-1:0]             stat_hi;  // 0x07
        logic [DATA_W-1:0]             line_sz;  // 0x0C
        logic [DATA_W-1:0]             lat_tmr;  // 0x0D
        logic [CHIP_N-1:0][DATA_W-1:0] chip;     // 0x50..0x61
    } cfg_state_t;

    function automatic logic [DATA_W-1:0] chip_reset(input int idx);
        case (idx)
            0:       return {5'b0, CACHE_LOW_BITS};
            1, 2:    return 8'h01;
            10:      return 8'h04;
            12:      return 8'hC0;
            13:      return 8'h20;
            15:      return 8'hFF;
            16:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_state_t state_reset();
        cfg_state_t s;
        s = '0;
        s.stat_hi = STAT_RST;
        for (int i = 0; i < CHIP_N; i++) s.chip[i] = chip_reset(i);
        return s;
    endfunction
endpackage

// File: rtl/hb_cfg_decode.sv
module hb_cfg_decode
    import hb_cfg_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output wrule_e           rule,
    output logic [IDX_W-1:0] chip_idx
);
    logic [OFF_W-1:0] rel;

    always_comb begin
        rel      = off - CHIP_LO;
        chip_idx = rel[IDX_W-1:0];
        rule     = RULE_RO;
        case (off)
            8'h04, 8'h05, 8'h0C, 8'h0D: rule = RULE_PLAIN;
            8'h07:                      rule = RULE_W1C;
            CHIP_LO:                    rule = RULE_HWLOW;
            default: begin
                if (off > CHIP_LO && off <= CHIP_HI) rule = RULE_PLAIN;
            end
        endcase
    end
endmodule

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs
    import hb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_ok,
    input  wrule_e            rule,
    input  logic [OFF_W-1:0]  off,
    input  logic [IDX_W-1:0]  chip_idx,
    input  logic [DATA_W-1:0] wdata,
    output cfg_state_t        state_q
);
    cfg_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (we_ok) begin
            unique case (rule)
                RULE_PLAIN: begin
                    case (off)
                        8'h04:   state_d.cmd_lo  = wdata;
                        8'h05:   state_d.cmd_hi  = wdata;
                        8'h0C:   state_d.line_sz = wdata;
                        8'h0D:   state_d.lat_tmr = wdata;
                        default: state_d.chip[chip_idx] = wdata;
                    endcase
                end
                RULE_W1C:   state_d.stat_hi = state_q.stat_hi & ~(wdata & STAT_CLR_MASK);
                RULE_HWLOW: state_d.chip[chip_idx] = {wdata[7:3], CACHE_LOW_BITS};
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= state_reset();
        else        state_q <= state_d;
    end

    // R4: status byte may only lose set bits, never gain them
    p_stat_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.stat_hi & ~$past(state_q.stat_hi)) == 8'h00));

    // R3: no accepted write to a writable offset means no state change
    p_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_ok || rule == RULE_RO) |=> $stable(state_q));
endmodule

// File: rtl/hb_cfg_rdmux.sv
module hb_cfg_rdmux
    import hb_cfg_pkg::*;
#(
    parameter int FUNC_W = 3
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    input  wrule_e            rule,
    input  logic [IDX_W-1:0]  chip_idx,
    input  cfg_state_t        state_q,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (func != '0) begin
            rdata = '1;
        end else begin
            case (off)
                8'h00: rdata = ID_B0;
                8'h01: rdata = ID_B1;
                8'h02: rdata = ID_B2;
                8'h03: rdata = ID_B3;
                8'h04: rdata = state_q.cmd_lo;
                8'h05: rdata = state_q.cmd_hi;
                8'h07: rdata = state_q.stat_hi;
                8'h08: rdata = REV_B;
                8'h0B: rdata = CLS_B;
                8'h0C: rdata = state_q.line_sz;
                8'h0D: rdata = state_q.lat_tmr;
                default: begin
                    if (rule == RULE_PLAIN || rule == RULE_HWLOW)
                        rdata = state_q.chip[chip_idx];
                end
            endcase
        end
    end
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
    import hb_cfg_pkg::*;
#(
    parameter int FUNC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_off,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    output logic [7:0]        reg50_o,
    output logic [7:0]        reg54_o,
    output logic [7:0]        reg55_o,
    output logic [7:0]        reg60_o,
    output logic              cache_en_o
);
    localparam int IDX50 = int'(8'h50) - int'(CHIP_LO);
    localparam int IDX54 = int'(8'h54) - int'(CHIP_LO);
    localparam int IDX55 = int'(8'h55) - int'(CHIP_LO);
    localparam int IDX60 = int'(8'h60) - int'(CHIP_LO);

    wrule_e           rule;
    logic [IDX_W-1:0] chip_idx;
    cfg_state_t       state_q;
    logic             we_ok;

    assign we_ok = cfg_we && (cfg_func == '0);

    hb_cfg_decode u_dec (
        .off      (cfg_off),
        .rule     (rule),
        .chip_idx (chip_idx)
    );

    hb_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_ok    (we_ok),
        .rule     (rule),
        .off      (cfg_off),
        .chip_idx (chip_idx),
        .wdata    (cfg_wdata),
        .state_q  (state_q)
    );

    hb_cfg_rdmux #(.FUNC_W(FUNC_W)) u_rd (
        .func     (cfg_func),
        .off      (cfg_off),
        .rule     (rule),
        .chip_idx (chip_idx),
        .state_q  (state_q),
        .rdata    (cfg_rdata)
    );

    assign reg50_o    = state_q.chip[IDX50];
    assign reg54_o    = state_q.chip[IDX54];
    assign reg55_o    = state_q.chip[IDX55];
    assign reg60_o    = state_q.chip[IDX60];
    assign cache_en_o = reg50_o[7];

    // R1: other functions read all ones
    p_func_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |-> (cfg_rdata == 8'hFF));

    // R5: hardwired cache-size code holds in every cycle
    p_hwlow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (reg50_o[2:0] == 3'b100));

    // R6: cache enable follows a write to 0x50
    p_cache_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ok && cfg_off == 8'h50) |=> (cache_en_o == $past(cfg_wdata[7])));

    // R2: plain write to 0x54 shows on the decode output next cycle
    p_plain54_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ok && cfg_off == 8'h54) |=> (reg54_o == $past(cfg_wdata)));
endmodule

// File: tb/sim_hb_cfg_space.sv
module sim_hb_cfg_space;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_func = '0;
    logic [7:0] cfg_off = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_rdata, reg50_o, reg54_o, reg55_o, reg60_o;
    logic       cache_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_cfg_space u0 (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
        .reg50_o(reg50_o), .reg54_o(reg54_o), .reg55_o(reg55_o),
        .reg60_o(reg60_o), .cache_en_o(cache_en_o)
    );

    function automatic logic [7:0] exp_rst(input int o);
        case (o)
            8'h00: return 8'h60;  8'h01: return 8'h10;
            8'h02: return 8'h81;  8'h03: return 8'h88;
            8'h07: return 8'h02;  8'h08: return 8'h04;
            8'h0B: return 8'h06;  8'h50: return 8'h04;
            8'h51, 8'h52: return 8'h01;
            8'h5A: return 8'h04;  8'h5C: return 8'hC0;
            8'h5D: return 8'h20;  8'h5F: return 8'hFF;
            8'h60: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] o, input logic [7:0] v);
        @(negedge clk);
        cfg_func = f; cfg_off = o; cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_func = '0;
    endtask

    task automatic rd(input logic [2:0] f, input logic [7:0] o, output logic [7:0] v);
        cfg_func = f; cfg_off = o;
        #1;
        v = cfg_rdata;
        cfg_func = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_values();
        logic [7:0] v;
        for (int o = 0; o < 256; o++) begin
            rd(3'd0, 8'(o), v);
            check($sformatf("R7/R9 reset off %02h", o), v, exp_rst(o));
        end
        check("R5 reset 0x50 output", reg50_o, 8'h04);
        check("R8 reset 0x54 output", reg54_o, 8'h00);
        check("R8 reset 0x55 output", reg55_o, 8'h00);
        check("R8 reset 0x60 output", reg60_o, 8'h80);
        check("R6 reset cache_en", {7'b0, cache_en_o}, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] v, pat;
        logic [7:0] offs [4] = '{8'h04, 8'h05, 8'h0C, 8'h0D};
        foreach (offs[i]) begin
            pat = offs[i] ^ 8'hA5;
            wr(3'd0, offs[i], pat);
            rd(3'd0, offs[i], v);
            check($sformatf("R2 plain off %02h", offs[i]), v, pat);
        end
        for (int o = 8'h51; o <= 8'h61; o++) begin
            pat = 8'(o) ^ 8'h3C;
            wr(3'd0, 8'(o), pat);
            rd(3'd0, 8'(o), v);
            check($sformatf("R2 plain off %02h", o), v, pat);
        end
        wr(3'd0, 8'h54, 8'hFF);
        check("R8 reg54 output", reg54_o, 8'hFF);
        wr(3'd0, 8'h55, 8'h00);
        check("R8 reg55 output", reg55_o, 8'h00);
        wr(3'd0, 8'h60, 8'h21);
        check("R8 reg60 output", reg60_o, 8'h21);
        rd(3'd0, 8'h60, v);
        check("R8 reg60 matches read", v, reg60_o);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        logic [7:0] offs [14] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h06, 8'h08, 8'h09,
                                   8'h0A, 8'h0B, 8'h0E, 8'h40, 8'h4F, 8'h62, 8'hFF};
        foreach (offs[i]) begin
            wr(3'd0, offs[i], 8'h5A);
            rd(3'd0, offs[i], v);
            check($sformatf("R3 ignored off %02h", offs[i]), v, exp_rst(int'(offs[i])));
        end
        wr(3'd0, 8'h54, 8'h11);
        wr(3'd2, 8'h54, 8'hEE);
        check("R3 other function write ignored", reg54_o, 8'h11);
        rd(3'd0, 8'h54, v);
        check("R3 other function write readback", v, 8'h11);
        for (int f = 1; f < 8; f++) begin
            rd(3'(f), 8'h00, v);
            check($sformatf("R1 func %0d off 00", f), v, 8'hFF);
        end
        rd(3'd5, 8'h54, v);
        check("R1 func 5 off 54", v, 8'hFF);
        rd(3'd7, 8'hFF, v);
        check("R1 func 7 off FF", v, 8'hFF);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wr(3'd0, 8'h07, 8'h00);
        rd(3'd0, 8'h07, v);
        check("R4 write zero keeps status", v, 8'h02);
        wr(3'd0, 8'h07, 8'hFF);
        rd(3'd0, 8'h07, v);
        check("R4 unmasked bit 1 survives all-ones", v, 8'h02);
        wr(3'd0, 8'h07, 8'h02);
        rd(3'd0, 8'h07, v);
        check("R4 direct write to bit 1 ignored", v, 8'h02);
    endtask

    task automatic t_cache_reg();
        logic [7:0] v;
        wr(3'd0, 8'h50, 8'hFF);
        rd(3'd0, 8'h50, v);
        check("R5 write FF reads FC", v, 8'hFC);
        check("R6 cache_en set", {7'b0, cache_en_o}, 8'h01);
        wr(3'd0, 8'h50, 8'h00);
        rd(3'd0, 8'h50, v);
        check("R5 write 00 reads 04", v, 8'h04);
        check("R6 cache_en clear", {7'b0, cache_en_o}, 8'h00);
        wr(3'd0, 8'h50, 8'h5B);
        rd(3'd0, 8'h50, v);
        check("R5 write 5B reads 5C", v, 8'h5C);
        check("R8 reg50 output", reg50_o, 8'h5C);
        wr(3'd0, 8'h50, 8'h83);
        check("R6 cache_en follows bit 7", {7'b0, cache_en_o}, 8'h01);
        check("R5 low bits after 83", reg50_o, 8'h84);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        do_reset();
        rd(3'd0, 8'h54, v);  check("R7 re-reset 0x54", v, 8'h00);
        rd(3'd0, 8'h60, v);  check("R7 re-reset 0x60", v, 8'h80);
        rd(3'd0, 8'h5F, v);  check("R7 re-reset 0x5F", v, 8'hFF);
        rd(3'd0, 8'h04, v);  check("R7 re-reset 0x04", v, 8'h00);
        rd(3'd0, 8'h50, v);  check("R7 re-reset 0x50", v, 8'h04);
        check("R6 re-reset cache_en", {7'b0, cache_en_o}, 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset_values();
        t_plain();
        t_ignored();
        t_w1c();
        t_cache_reg();
        t_reset_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule